// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles using a single adder no wider than one operand. It keeps one accumulator register twice the operand width. The multiplier operand is parked in the lower half of that register, and the upper half starts cleared. On every iteration the controller looks at the accumulator's least significant bit. When that bit is one, it adds the multiplicand into the upper half. Then the whole register moves right by one place, with the adder's carry entering at the top. After one iteration per multiplier bit, the multiplier has been shifted out completely and the register holds the full product.

A caller drives both operands and pulses `start` while the block is idle. `busy` stays high through the iterations. `done` pulses for one cycle when the result is ready, and `product` then keeps its value until the next accepted start. The interface is plain control: there is no valid/ready stream. A start that arrives while the block is busy is not queued and has no effect.

Top module: `shiftadd_mult`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all zero.
- R2: A `start` pulse sampled while `busy` is low loads the operands. In the next cycle `busy` is high, and `product` shows the upper half as zero and the lower half as the multiplier input `op_b` (bits W-1:0).
- R3: When `done` is high, `product` equals the unsigned product `op_a * op_b` of the operands that were loaded. This holds for extreme operand values. The carry out of the W-bit add must reach bit 2W-1, for example 255*255 = 65025.
- R4: After the loading edge, exactly W iteration edges take place (W = 8 by default). `done` goes high for exactly one cycle after the W-th iteration, and `busy` goes low in that same cycle.
- R5: A `start` sampled while `busy` is high is ignored. The running result, the operands in use and the timing of `done` are unchanged.
- R6: After `done`, `product` holds its value, with no `start` applied, until the next accepted start.
- R7: A `start` sampled in the cycle where `done` is high is accepted, because `busy` is low then.
- R8: For example, 147 * 85 gives 12495 (0x30CF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request; accepted only while not busy |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: result ready |
| product | output | 2W | Accumulator and final product |

## Verification
Some behaviours are checked by assertions on every cycle:
- `done` is a single-cycle pulse that never overlaps `busy`.
- A start during busy does not stop the run early.
- The lower half of the accumulator equals the multiplier right after a load.
- An iteration without an add clears the top bit.
- When `done` is high, the result matches the product of the captured operands.

Other behaviours only the directed scenarios can show:
- The exact cycle position of `done` relative to the start.
- That the result holds after `done`.
- That a start in the `done` cycle is accepted.
- The specific operand corners: zero, one, maximum values and the worked 147*85 case.

// File: rtl/shiftadd_mult_pkg.sv
package shiftadd_mult_pkg;
  localparam int unsigned DEF_W = 8;
endpackage

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] iter_q;
  logic          busy_q, done_q;

  assign load = start & ~busy_q;
  assign step = busy_q;
  assign busy = busy_q;
  assign done = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        iter_q <= '0;
      end else if (busy_q) begin
        iter_q <= iter_q + 1'b1;
        if (iter_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R4: done lasts one cycle and never overlaps busy
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R5: a start during a run does not cut it short
  a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && iter_q != LAST) |=> (busy_q && !done_q));
endmodule

// File: rtl/shiftadd_dpath.sv
module shiftadd_dpath #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] acc
);
  logic [2*W-1:0] acc_q;
  logic [W-1:0]   mcand_q;
  logic [W:0]     sum;

  // W-bit add into the upper half, carry kept as bit W
  assign sum = {1'b0, acc_q[2*W-1:W]} + {1'b0, mcand_q};
  assign acc = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{W{1'b0}}, mplier_in};
      mcand_q <= mcand_in;
    end else if (step) begin
      if (acc_q[0]) acc_q <= {sum, acc_q[W-1:1]};
      else          acc_q <= {1'b0, acc_q[2*W-1:1]};
    end
  end

  // R2: the multiplier sits in the lower half right after a load
  a_r2_load_lower: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (acc_q == {{W{1'b0}}, $past(mplier_in)}));
  // R3: a step without an add shifts a zero into the top bit
  a_r3_noadd_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !acc_q[0]) |=> !acc_q[2*W-1]);
  // R6: the accumulator is frozen when neither loading nor stepping
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(acc_q));
endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int unsigned W = shiftadd_mult_pkg::DEF_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic load, step;

  shiftadd_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  shiftadd_dpath #(.W(W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .mcand_in(op_a), .mplier_in(op_b), .acc(product)
  );

  // Operand copies used only by the result check below
  logic [W-1:0] chk_a, chk_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_a <= '0;
      chk_b <= '0;
    end else if (load) begin
      chk_a <= op_a;
      chk_b <= op_b;
    end
  end

  // R3: the finished result equals the product of the captured operands
  a_r3_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ({{W{1'b0}}, chk_a} * {{W{1'b0}}, chk_b})));
endmodule

// File: tb/tb_shiftadd_mult.sv
`timescale 1ns/1ps
module tb_shiftadd_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   op_a = '0, op_b = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shiftadd_mult #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start at a negedge; returns at the negedge after the loading edge.
  task automatic kick(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 product", 32'(product), 0);
  endtask

  // Full run, checks load view, done timing and result
  task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    kick(a, b);
    check("R2 busy after start", 32'(busy), 1);
    check("R2 lower half holds multiplier", 32'(product), 32'(b));
    repeat (W - 1) @(negedge clk);
    check("R4 no early done", 32'(done), 0);
    @(negedge clk);
    check("R4 done after W iterations", 32'(done), 1);
    check("R4 busy low with done", 32'(busy), 0);
    check(req, 32'(product), 32'(a) * 32'(b));
  endtask

  task automatic t_hold();
    logic [2*W-1:0] keep;
    keep = product;
    @(negedge clk);
    check("R4 done one cycle", 32'(done), 0);
    repeat (5) @(negedge clk);
    check("R6 product held", 32'(product), 32'(keep));
  endtask

  task automatic t_busy_start();
    kick(8'd200, 8'd3);
    repeat (2) @(negedge clk);
    kick(8'd9, 8'd9);
    // the loading edge above was an iteration edge; 5 iterations remain
    repeat (4) @(negedge clk);
    check("R5 done timing kept", 32'(done), 0);
    @(negedge clk);
    check("R5 done on time", 32'(done), 1);
    check("R5 original result", 32'(product), 600);
  endtask

  task automatic t_start_on_done();
    t_mul(8'd12, 8'd13, "R3 12*13");
    kick(8'd7, 8'd11);
    check("R7 accepted in done cycle", 32'(busy), 1);
    check("R7 new multiplier loaded", 32'(product), 11);
    repeat (W) @(negedge clk);
    check("R7 second result", 32'(product), 77);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mul(8'd147, 8'd85, "R8 147*85=12495");
        t_hold();
        t_mul(8'd255, 8'd255, "R3 max carry");
        t_mul(8'd0, 8'd173, "R3 zero multiplicand");
        t_mul(8'd91, 8'd0, "R3 zero multiplier");
        t_mul(8'd1, 8'd1, "R3 one");
        t_mul(8'd255, 8'd128, "R3 top bit multiplier");
        t_mul(8'd170, 8'd85, "R3 alternating");
        @(negedge clk);
        t_busy_start();
        @(negedge clk);
        t_start_on_done();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule